// File: doc/BRIEF.md
# Memory-Reference Decode and Execute Unit

This unit sits in the decode stage of a 12-bit single-accumulator processor. For each presented instruction word it classifies the opcode, raises the memory-access control flags that the sequencer needs (operand read, operand write, possible change of flow, pointer fetch, pointer autoincrement), forms the 15-bit operand or pointer address from the data field, the current page and the low instruction bits, and computes the default next program counter.

The same unit also evaluates the execute step of the six memory-reference operations. The sequencer supplies the accumulator, link, the operand word fetched from memory and the resolved final address. The unit returns the new accumulator and link, the word to write back and the program counter to continue from. A pending interrupt is taken by substituting a subroutine call to location 0 without advancing the PC. I/O transfer and operate instructions are flagged as illegal here and leave every piece of state unchanged. All results appear on registered outputs one clock after a valid input.

Top module: `mref_decode_unit`

## Requirements
- R1: The opcode class is instruction bits 11:9 (0 AND, 1 add-with-link, 2 increment-and-skip, 3 deposit-and-clear, 4 subroutine call, 5 jump). Operand read is raised for classes 0, 1 and 2, operand write for 2, 3 and 4, and possible redirect for 2, 4 and 5.
- R2: The default next PC is the PC with its low 12 bits incremented modulo 4096, and bits 14:12 unchanged.
- R3: The address is {data field, bits 11:7 of the default next PC when instruction bit 7 is 1 and otherwise zero, instruction bits 6:0}.
- R4: When instruction bit 8 is 1 the pointer-fetch flag is raised and the address names a pointer. Otherwise the flag is low.
- R5: The autoincrement flag is raised only for a pointer fetch whose class cannot redirect and whose instruction bits 6:3 equal 4'b0001.
- R6: With the interrupt request high, the word is replaced by octal 4000 and the default next PC equals the PC. The call stores the PC and continues at address 1 of field 0.
- R7: AND replaces the accumulator with accumulator AND operand. The link is unchanged.
- R8: Add-with-link forms link*4096 + accumulator + operand. The result link is sum bit 12 and the result accumulator is the sum's low 12 bits.
- R9: Increment-and-skip writes (operand+1) mod 4096. When that is zero, the next PC is the default next PC advanced once more in its low 12 bits with wrap.
- R10: Deposit-and-clear writes the accumulator and returns a zero accumulator.
- R11: A subroutine call writes the low 12 bits of the default next PC and continues at {instruction field, (final address low 12 bits + 1) mod 4096}.
- R12: A jump continues at {instruction field, final address low 12 bits}. All other legal classes continue at the default next PC.
- R13: Class 6, class 7, or an interrupt with a nonzero data or instruction field raises the illegal output. When this happens all five control flags, the address and the write word are zero, the accumulator and link pass through, and the next PC equals the PC.
- R14: Every output is zero after reset. The output valid bit follows the input valid bit one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| insn | input | 12 | Instruction word |
| pc | input | 15 | Current program counter (field and 12-bit offset) |
| dfld | input | 3 | Data field |
| ifld | input | 3 | Instruction field |
| irq | input | 1 | Interrupt request |
| acc_in | input | 12 | Accumulator |
| link_in | input | 1 | Link bit |
| opnd_in | input | 12 | Operand word read from memory |
| final_addr | input | 15 | Resolved operand address |
| out_valid | output | 1 | Outputs valid |
| op_class | output | 3 | Opcode class |
| need_load | output | 1 | Operand read needed |
| need_store | output | 1 | Operand write needed |
| may_redirect | output | 1 | May change the flow |
| need_indirect | output | 1 | Address is a pointer |
| need_autoinc | output | 1 | Pointer write-back with increment |
| illegal | output | 1 | Unsupported encoding |
| ea | output | 15 | Operand or pointer address |
| npc_dflt | output | 15 | Default next PC |
| res_acc | output | 12 | New accumulator |
| res_link | output | 1 | New link |
| res_wdata | output | 12 | Word to write back |
| res_next_pc | output | 15 | PC to continue from |

## Verification
The bench targets PC wrap at the top of a field, where a design that carries into the field bits would leave the field. It also targets a skip from offset 7777, which has to wrap to 0000 in the same field. Current-page addressing near a page edge and the autoincrement window exercise the rules for bits 6:3 and for a redirecting class, and an error there would fetch from the wrong page or corrupt a jump pointer. Add-with-link with link and accumulator both full checks that the sum's bit 13 is dropped. Interrupt entry with a nonzero field checks that a faulty design neither advances the PC nor runs the substituted call.

// File: rtl/mref_pkg.sv
package mref_pkg;

    localparam int WORD_W   = 12;
    localparam int FIELD_W  = 3;
    localparam int ADDR_W   = WORD_W + FIELD_W;
    localparam int PAGE_LSB = 7;
    localparam int PAGE_W   = WORD_W - PAGE_LSB;
    localparam logic [WORD_W-1:0] IRQ_WORD = 12'o4000;

    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_TAD = 3'd1,
        OP_ISZ = 3'd2,
        OP_DCA = 3'd3,
        OP_JMS = 3'd4,
        OP_JMP = 3'd5,
        OP_IOT = 3'd6,
        OP_OPR = 3'd7
    } opclass_e;

    typedef struct packed {
        logic load;
        logic store;
        logic redirect;
        logic indirect;
        logic autoinc;
        logic illegal;
    } ctl_t;

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic              link;
        logic [WORD_W-1:0] wdata;
        logic [ADDR_W-1:0] next_pc;
    } exec_t;

    // Advance the offset part of an address, keeping its field.
    function automatic logic [ADDR_W-1:0] offset_inc(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:WORD_W], a[WORD_W-1:0] + WORD_W'(1)};
    endfunction

endpackage

// File: rtl/mref_addr_gen.sv
module mref_addr_gen
    import mref_pkg::*;
(
    input  logic [WORD_W-1:0]  insn,
    input  logic [ADDR_W-1:0]  pc,
    input  logic [FIELD_W-1:0] dfld,
    input  logic [FIELD_W-1:0] ifld,
    input  logic               irq,
    output opclass_e           op,
    output ctl_t               ctl,
    output logic [ADDR_W-1:0]  ea,
    output logic [ADDR_W-1:0]  npc
);
    logic [WORD_W-1:0] word;
    logic              irq_bad;
    logic              mem_ref;
    logic [PAGE_W-1:0] page_bits;

    always_comb begin
        irq_bad   = irq && ((dfld != '0) || (ifld != '0));
        word      = irq ? IRQ_WORD : insn;
        npc       = irq ? pc : offset_inc(pc);
        op        = opclass_e'(word[WORD_W-1:WORD_W-3]);

        ctl.illegal  = irq_bad || (op == OP_IOT) || (op == OP_OPR);
        ctl.load     = !ctl.illegal && (op == OP_AND || op == OP_TAD || op == OP_ISZ);
        ctl.store    = !ctl.illegal && (op == OP_ISZ || op == OP_DCA || op == OP_JMS);
        ctl.redirect = !ctl.illegal && (op == OP_ISZ || op == OP_JMS || op == OP_JMP);
        mem_ref      = ctl.load || ctl.store || ctl.redirect;
        ctl.indirect = mem_ref && word[8];
        ctl.autoinc  = ctl.indirect && !ctl.redirect && (word[6:3] == 4'b0001);

        page_bits = word[PAGE_LSB] ? npc[WORD_W-1:PAGE_LSB] : '0;
        ea        = mem_ref ? {dfld, page_bits, word[PAGE_LSB-1:0]} : '0;
    end
endmodule

// File: rtl/mref_exec.sv
module mref_exec
    import mref_pkg::*;
(
    input  opclass_e           op,
    input  logic               illegal,
    input  logic [FIELD_W-1:0] ifld,
    input  logic [ADDR_W-1:0]  pc,
    input  logic [ADDR_W-1:0]  npc,
    input  logic [WORD_W-1:0]  acc,
    input  logic               link,
    input  logic [WORD_W-1:0]  opnd,
    input  logic [ADDR_W-1:0]  final_addr,
    output exec_t              res
);
    logic [WORD_W:0]   sum;
    logic [WORD_W-1:0] inc;

    always_comb begin
        sum = {1'b0, acc} + {1'b0, opnd} + {link, {WORD_W{1'b0}}};
        inc = opnd + WORD_W'(1);

        res.acc     = acc;
        res.link    = link;
        res.wdata   = '0;
        res.next_pc = npc;

        if (illegal) begin
            res.next_pc = pc;
        end else begin
            unique case (op)
                OP_AND: res.acc = acc & opnd;
                OP_TAD: {res.link, res.acc} = sum;
                OP_ISZ: begin
                    res.wdata = inc;
                    if (inc == '0) res.next_pc = offset_inc(npc);
                end
                OP_DCA: begin
                    res.wdata = acc;
                    res.acc   = '0;
                end
                OP_JMS: begin
                    res.wdata   = npc[WORD_W-1:0];
                    res.next_pc = {ifld, final_addr[WORD_W-1:0] + WORD_W'(1)};
                end
                OP_JMP: res.next_pc = {ifld, final_addr[WORD_W-1:0]};
                default: res.next_pc = pc;
            endcase
        end
    end
endmodule

// File: rtl/mref_decode_unit.sv
module mref_decode_unit
    import mref_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [11:0] insn,
    input  logic [14:0] pc,
    input  logic [2:0]  dfld,
    input  logic [2:0]  ifld,
    input  logic        irq,
    input  logic [11:0] acc_in,
    input  logic        link_in,
    input  logic [11:0] opnd_in,
    input  logic [14:0] final_addr,
    output logic        out_valid,
    output logic [2:0]  op_class,
    output logic        need_load,
    output logic        need_store,
    output logic        may_redirect,
    output logic        need_indirect,
    output logic        need_autoinc,
    output logic        illegal,
    output logic [14:0] ea,
    output logic [14:0] npc_dflt,
    output logic [11:0] res_acc,
    output logic        res_link,
    output logic [11:0] res_wdata,
    output logic [14:0] res_next_pc
);
    opclass_e          op_c;
    ctl_t              ctl_c, ctl_q;
    logic [ADDR_W-1:0] ea_c, npc_c;
    exec_t             ex_c, ex_q;

    mref_addr_gen u_addr (
        .insn (insn),
        .pc   (pc),
        .dfld (dfld),
        .ifld (ifld),
        .irq  (irq),
        .op   (op_c),
        .ctl  (ctl_c),
        .ea   (ea_c),
        .npc  (npc_c)
    );

    mref_exec u_exec (
        .op         (op_c),
        .illegal    (ctl_c.illegal),
        .ifld       (ifld),
        .pc         (pc),
        .npc        (npc_c),
        .acc        (acc_in),
        .link       (link_in),
        .opnd       (opnd_in),
        .final_addr (final_addr),
        .res        (ex_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            op_class  <= '0;
            ctl_q     <= '0;
            ea        <= '0;
            npc_dflt  <= '0;
            ex_q      <= '0;
        end else begin
            out_valid <= in_valid;
            op_class  <= op_c;
            ctl_q     <= ctl_c;
            ea        <= ea_c;
            npc_dflt  <= npc_c;
            ex_q      <= ex_c;
        end
    end

    assign need_load     = ctl_q.load;
    assign need_store    = ctl_q.store;
    assign may_redirect  = ctl_q.redirect;
    assign need_indirect = ctl_q.indirect;
    assign need_autoinc  = ctl_q.autoinc;
    assign illegal       = ctl_q.illegal;
    assign res_acc       = ex_q.acc;
    assign res_link      = ex_q.link;
    assign res_wdata     = ex_q.wdata;
    assign res_next_pc   = ex_q.next_pc;
endmodule

// File: rtl/mref_decode_unit_chk.sv
module mref_decode_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [14:0] pc,
    input logic [2:0]  ifld,
    input logic        irq,
    input logic [11:0] acc_in,
    input logic        out_valid,
    input logic [2:0]  op_class,
    input logic        need_load,
    input logic        need_store,
    input logic        may_redirect,
    input logic        need_indirect,
    input logic        need_autoinc,
    input logic        illegal,
    input logic [14:0] npc_dflt,
    input logic [11:0] res_acc,
    input logic [11:0] res_wdata,
    input logic [14:0] res_next_pc
);
    p_valid_follow_r14: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid));

    p_illegal_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        (out_valid && illegal) |->
            (!need_load && !need_store && !may_redirect && !need_indirect &&
             res_next_pc == $past(pc)));

    p_autoinc_window_r5: assert property (@(posedge clk) disable iff (rst)
        need_autoinc |-> (need_indirect && !may_redirect));

    p_field_kept_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal && !$past(irq)) |-> npc_dflt[14:12] == $past(pc[14:12]));

    p_jump_field_r12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal && (op_class == 3'd4 || op_class == 3'd5)) |->
            res_next_pc[14:12] == $past(ifld));

    p_deposit_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal && op_class == 3'd3) |->
            (res_acc == 12'd0 && res_wdata == $past(acc_in)));

    p_irq_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal && $past(irq)) |->
            (npc_dflt == $past(pc) && op_class == 3'd4));
endmodule

bind mref_decode_unit mref_decode_unit_chk u_chk (.*);

// File: tb/mref_decode_unit_test.sv
module mref_decode_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] insn = '0;
    logic [14:0] pc = '0;
    logic [2:0]  dfld = '0;
    logic [2:0]  ifld = '0;
    logic        irq = 1'b0;
    logic [11:0] acc_in = '0;
    logic        link_in = 1'b0;
    logic [11:0] opnd_in = '0;
    logic [14:0] final_addr = '0;
    logic        out_valid;
    logic [2:0]  op_class;
    logic        need_load, need_store, may_redirect, need_indirect, need_autoinc, illegal;
    logic [14:0] ea, npc_dflt, res_next_pc;
    logic [11:0] res_acc, res_wdata;
    logic        res_link;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mref_decode_unit uut (.*);

    typedef struct packed {
        logic [11:0] w;
        logic [14:0] p;
        logic [2:0]  d;
        logic [2:0]  f;
        logic        q;
        logic [11:0] a;
        logic        l;
        logic [11:0] o;
        logic [14:0] fa;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VTAB [NV] = '{
        '{12'o0123, 15'o00200, 3'o0, 3'o0, 1'b0, 12'o7070, 1'b1, 12'o0707, 15'o00123},
        '{12'o0323, 15'o00200, 3'o1, 3'o0, 1'b0, 12'o7777, 1'b0, 12'o1234, 15'o10323},
        '{12'o1005, 15'o01000, 3'o0, 3'o0, 1'b0, 12'o0001, 1'b0, 12'o0002, 15'o00005},
        '{12'o1377, 15'o04177, 3'o2, 3'o0, 1'b0, 12'o7777, 1'b0, 12'o0001, 15'o24177},
        '{12'o1410, 15'o00050, 3'o0, 3'o0, 1'b0, 12'o4000, 1'b1, 12'o4000, 15'o00333},
        '{12'o2020, 15'o00400, 3'o0, 3'o0, 1'b0, 12'o0000, 1'b0, 12'o0041, 15'o00020},
        '{12'o2617, 15'o00177, 3'o3, 3'o0, 1'b0, 12'o0000, 1'b0, 12'o7777, 15'o30212},
        '{12'o3150, 15'o07600, 3'o0, 3'o0, 1'b0, 12'o2525, 1'b1, 12'o0000, 15'o00150},
        '{12'o3411, 15'o00010, 3'o0, 3'o0, 1'b0, 12'o0017, 1'b0, 12'o0000, 15'o01000},
        '{12'o4200, 15'o51111, 3'o5, 3'o6, 1'b0, 12'o0000, 1'b0, 12'o0000, 15'o51000},
        '{12'o4417, 15'o00001, 3'o0, 3'o2, 1'b0, 12'o0000, 1'b0, 12'o0000, 15'o07777},
        '{12'o5377, 15'o02000, 3'o0, 3'o4, 1'b0, 12'o0000, 1'b0, 12'o0000, 15'o02177},
        '{12'o5413, 15'o00000, 3'o0, 3'o0, 1'b0, 12'o0000, 1'b0, 12'o0000, 15'o06543},
        '{12'o6032, 15'o00300, 3'o0, 3'o0, 1'b0, 12'o1111, 1'b1, 12'o0000, 15'o00000},
        '{12'o7300, 15'o00300, 3'o0, 3'o0, 1'b0, 12'o2222, 1'b0, 12'o0000, 15'o00000},
        '{12'o1000, 15'o00456, 3'o0, 3'o0, 1'b1, 12'o0005, 1'b1, 12'o0000, 15'o00000},
        '{12'o0000, 15'o00456, 3'o2, 3'o0, 1'b1, 12'o0005, 1'b1, 12'o0000, 15'o00000},
        '{12'o0430, 15'o00000, 3'o0, 3'o0, 1'b0, 12'o0707, 1'b0, 12'o7000, 15'o00555}
    };

    // Expected outputs derived from the requirements:
    // {op3, load, store, redir, indir, autoinc, illegal, ea15, npc15, acc12, link, wdata12, next15}
    function automatic logic [78:0] model(input vec_t v);
        logic [11:0] w;
        logic [2:0]  op;
        logic        bad, ld, st, rd, ind, ai, mem;
        logic [14:0] npc, addr, nx;
        logic [11:0] acc, wd, t;
        logic        lk;
        logic [12:0] s;
        w   = v.q ? 12'o4000 : v.w;
        npc = v.q ? v.p : {v.p[14:12], 12'(v.p[11:0] + 12'd1)};
        op  = w[11:9];
        bad = (op >= 3'd6) || (v.q && (v.d != 3'd0 || v.f != 3'd0));
        ld  = !bad && (op <= 3'd2);
        st  = !bad && (op >= 3'd2 && op <= 3'd4);
        rd  = !bad && (op == 3'd2 || op == 3'd4 || op == 3'd5);
        mem = !bad;
        ind = mem && w[8];
        ai  = ind && !rd && (w[6:3] == 4'd1);
        addr = mem ? {v.d, (w[7] ? npc[11:7] : 5'd0), w[6:0]} : 15'd0;
        acc = v.a; lk = v.l; wd = 12'd0; nx = npc;
        if (bad) nx = v.p;
        else if (op == 3'd0) acc = v.a & v.o;
        else if (op == 3'd1) begin
            s = 13'(v.a) + 13'(v.o) + (v.l ? 13'd4096 : 13'd0);
            lk = s[12]; acc = s[11:0];
        end else if (op == 3'd2) begin
            t = v.o + 12'd1; wd = t;
            if (t == 12'd0) nx = {npc[14:12], 12'(npc[11:0] + 12'd1)};
        end else if (op == 3'd3) begin
            wd = v.a; acc = 12'd0;
        end else if (op == 3'd4) begin
            wd = npc[11:0]; nx = {v.f, 12'(v.fa[11:0] + 12'd1)};
        end else nx = {v.f, v.fa[11:0]};
        return {op, ld, st, rd, ind, ai, bad, addr, npc, acc, lk, wd, nx};
    endfunction

    function automatic logic [78:0] actual();
        return {op_class, need_load, need_store, may_redirect, need_indirect, need_autoinc,
                illegal, ea, npc_dflt, res_acc, res_link, res_wdata, res_next_pc};
    endfunction

    task automatic check(input string tag, input logic [78:0] act, input logic [78:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        insn = v.w; pc = v.p; dfld = v.d; ifld = v.f; irq = v.q;
        acc_in = v.a; link_in = v.l; opnd_in = v.o; final_addr = v.fa;
        in_valid = 1'b1;
        @(negedge clk);
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.q) return "R6/R13 interrupt";
        case (v.w[11:9])
            3'd0: return "R1 R3 R7 and";
            3'd1: return "R4 R8 add";
            3'd2: return "R9 isz";
            3'd3: return "R5 R10 dca";
            3'd4: return "R11 jms";
            3'd5: return "R12 jmp";
            default: return "R13 illegal";
        endcase
    endfunction

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        // R14: reset state
        check("R14 reset", {out_valid, actual()}, 80'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VTAB[i]);
            check(tag_of(VTAB[i]), actual(), model(VTAB[i]));
            checks++;
            if (out_valid !== 1'b1) begin
                errors++;
                $display("FAIL R14 valid actual=%b expected=1", out_valid);
            end
        end

        // R2: wrap at top of field keeps field
        v = '{12'o0005, 15'o17777, 3'o0, 3'o0, 1'b0, 12'o0, 1'b0, 12'o0, 15'o5};
        drive(v);
        check("R2 wrap", 79'(npc_dflt), 79'(15'o10000));

        // R3: current page near page edge with data field 2
        v = '{12'o1217, 15'o02345, 3'o2, 3'o0, 1'b0, 12'o0, 1'b0, 12'o0, 15'o0};
        drive(v);
        check("R3 page ea", 79'(ea), 79'(15'o22217));

        // R5: autoinc window cases
        v = '{12'o0410, 15'o0, 3'o0, 3'o0, 1'b0, 12'o0, 1'b0, 12'o0, 15'o0};
        drive(v);
        check("R5 window lo", 79'({need_indirect, need_autoinc}), 79'(2'b11));
        v.w = 12'o0420;
        drive(v);
        check("R5 outside", 79'({need_indirect, need_autoinc}), 79'(2'b10));
        v.w = 12'o5410;
        drive(v);
        check("R5 jump no autoinc", 79'({need_indirect, need_autoinc}), 79'(2'b10));
        v.w = 12'o2417;
        drive(v);
        check("R5 isz no autoinc", 79'({need_indirect, need_autoinc}), 79'(2'b10));

        // R9: skip wraps within field
        v = '{12'o2050, 15'o37776, 3'o0, 3'o0, 1'b0, 12'o0, 1'b0, 12'o7777, 15'o50};
        drive(v);
        check("R9 skip wrap", 79'({res_wdata, res_next_pc}), 79'({12'o0000, 15'o30000}));

        // R8: full link and accumulator drop the carry out of bit 12
        v = '{12'o1020, 15'o0, 3'o0, 3'o0, 1'b0, 12'o7777, 1'b1, 12'o0001, 15'o20};
        drive(v);
        check("R8 top carry", 79'({res_link, res_acc}), 79'({1'b0, 12'o0000}));

        // R6: interrupt entry
        v = '{12'o7402, 15'o00123, 3'o0, 3'o0, 1'b1, 12'o0, 1'b0, 12'o0, 15'o0};
        drive(v);
        check("R6 irq", 79'({op_class, need_store, ea, res_wdata, res_next_pc}),
              79'({3'd4, 1'b1, 15'o0, 12'o0123, 15'o00001}));

        // R13: interrupt with nonzero instruction field
        v.f = 3'o1; v.a = 12'o4321; v.l = 1'b1;
        drive(v);
        check("R13 irq field", 79'({illegal, need_store, res_acc, res_link, res_next_pc}),
              79'({1'b1, 1'b0, 12'o4321, 1'b1, 15'o00123}));

        // R11: call from the end of a field wraps its target
        v = '{12'o4400, 15'o00010, 3'o0, 3'o3, 1'b0, 12'o0, 1'b0, 12'o0, 15'o17777};
        drive(v);
        check("R11 jms wrap", 79'({res_wdata, res_next_pc}), 79'({12'o0011, 15'o30000}));

        // R14: valid drops one clock after input valid drops
        in_valid = 1'b0;
        @(negedge clk);
        check("R14 valid low", 79'(out_valid), 79'(0));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule